// File: doc/BRIEF.md
# GPIO Port Edge Detector

An eight-pin edge-detection unit for a general-purpose I/O port. Each pin input is brought into the local clock domain by a two-flop synchroniser, and a change of the synchronised level in either direction counts as an edge. A pin is watched only while its enable bit is set and its direction bit marks it as an input. A detected edge latches a sticky status bit. Software clears that bit by writing a one to it.

Software reaches three registers through a flat address, write data, a write strobe and a combinational read data bus. The direction register is at offset 0x70, the enable register at 0x78 and the status register at 0x79. A level interrupt output is high while any status bit is set.

Top module: `gpio_edge_unit`

## Requirements
- R1: After reset the direction, enable and status registers all read 0x00 and irq_o is 0. Direction bit value 0 means input.
- R2: With we_i high at a clock edge, wdata_i is stored into direction (0x70) or enable (0x78) and reads back unchanged. A read of any other offset than 0x70, 0x78 or 0x79 returns 0x00.
- R3: Bit n of every register belongs to pin n. A rising or a falling change on an armed pin sets its status bit. The bit reads 0 at the second clock edge after the change and reads 1 from the third.
- R4: A pin whose enable bit is 0 never sets its status bit.
- R5: A pin whose direction bit is 1 (output) never sets its status bit, even when it is enabled.
- R6: Writing to the status register (0x79) clears each bit written as 1 and leaves each bit written as 0 unchanged. Such a write never sets a bit.
- R7: If an edge on an armed pin sets a status bit in the same cycle that a write of 1 clears it, the bit stays 1.
- R8: Clearing an enable bit does not change a status bit that is already set.
- R9: irq_o is 1 exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Asynchronous pin levels |
| addr_i | input | 8 | Register offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Level interrupt, OR of the status bits |

## Verification
The hardest case is the collision in R7, where a clear write and a new edge land on the same clock edge. The bench tracks the synchroniser latency exactly. It changes the pin one edge, waits two more edges, and then holds the write-one-to-clear strobe across the third edge, which is the edge where the status bit sets. In that same write, other set bits are cleared, so one write shows both outcomes. The latency itself is pinned by reading the status once at the second edge after the change, where it must still be 0, and again at the third edge.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 8;
  localparam int SYNC_N = 2;
  typedef logic [ADDR_W-1:0] reg_addr_t;
  localparam reg_addr_t OFS_DIR = 8'h70;
  localparam reg_addr_t OFS_EN  = 8'h78;
  localparam reg_addr_t OFS_STS = 8'h79;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;

  // any level change, either direction
  assign edge_o = sync_i ^ prev_q;

  a_r3_edge_on_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o == (sync_i ^ $past(sync_i)));
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] edge_i,
  input  reg_addr_t    addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         we_i,
  output logic [W-1:0] rdata_o,
  output logic         irq_o
);
  logic [W-1:0] dir_q, en_q, sts_q;
  logic [W-1:0] arm_v, set_v, clr_v;
  logic         wr_dir, wr_en, wr_sts;

  assign wr_dir = we_i && (addr_i == OFS_DIR);
  assign wr_en  = we_i && (addr_i == OFS_EN);
  assign wr_sts = we_i && (addr_i == OFS_STS);

  // armed: enabled and direction is input (0)
  assign arm_v = en_q & ~dir_q;
  assign set_v = edge_i & arm_v;
  assign clr_v = wr_sts ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dir_q <= '0;
      en_q  <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata_i;
      if (wr_en)  en_q  <= wdata_i;
    end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sts_q <= '0;
    else         sts_q <= set_v | (sts_q & ~clr_v);

  always_comb begin
    case (addr_i)
      OFS_DIR: rdata_o = dir_q;
      OFS_EN:  rdata_o = en_q;
      OFS_STS: rdata_o = sts_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |sts_q;

  a_r4_r5_set_only_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_q & ~$past(sts_q) & ~$past(arm_v)) == '0);

  a_r6_clear_written_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sts |=> ((sts_q & $past(wdata_i & ~set_v)) == '0));

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_v) |=> ((sts_q & $past(set_v)) == $past(set_v)));

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~sts_q & $past(sts_q) & ~$past(clr_v)) == '0);
endmodule

// File: rtl/gpio_edge_unit.sv
module gpio_edge_unit
  import gpio_edge_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PORT_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [PORT_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [PORT_W-1:0] sync_w, edge_w;

  gpio_sync #(.W(PORT_W), .STAGES(SYNC_N)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .sync_o(sync_w));

  gpio_edge_det #(.W(PORT_W)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_w), .edge_o(edge_w));

  gpio_edge_regs #(.W(PORT_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w),
    .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i),
    .rdata_o(rdata_o), .irq_o(irq_o));

  a_r9_irq_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (addr_i != 8'h79 || rdata_o != '0));
endmodule

// File: tb/sim_gpio_edge_unit.sv
`timescale 1ns/1ps
module sim_gpio_edge_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [7:0] pin = '0, addr = '0, wdata = '0;
  logic       we = 0;
  logic [7:0] rdata;
  logic       irq;

  gpio_edge_unit u0 (.clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .irq_o(irq));

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] val;
    logic       is_irq;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, bad = 0;
  logic rd_v = 0;
  logic done = 0;

  // monitor: compares at negedge, away from the active edge
  always @(negedge clk) begin
    if (rd_v && exp_q.size() > 0) begin
      exp_t e;
      logic [7:0] act;
      e = exp_q.pop_front();
      act = e.is_irq ? {7'd0, irq} : rdata;
      total++;
      if (act !== e.val) begin
        bad++;
        $display("FAIL %s: actual=%02h expected=%02h", e.tag, act, e.val);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    addr = a;
    e.val = exp; e.is_irq = 1'b0; e.tag = tag;
    exp_q.push_back(e);
    rd_v = 1;
    @(negedge clk); #1;
    rd_v = 0;
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    exp_t e;
    @(posedge clk); #1;
    e.val = {7'd0, exp}; e.is_irq = 1'b1; e.tag = tag;
    exp_q.push_back(e);
    rd_v = 1;
    @(negedge clk); #1;
    rd_v = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; we = 1;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(posedge clk); #1;
    pin = v;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    rd(8'h70, 8'h00, "R1 dir reset");
    rd(8'h78, 8'h00, "R1 en reset");
    rd(8'h79, 8'h00, "R1 sts reset");
    chk_irq(1'b0, "R1 irq reset");

    wr(8'h70, 8'hA5); rd(8'h70, 8'hA5, "R2 dir readback");
    wr(8'h78, 8'h3C); rd(8'h78, 8'h3C, "R2 en readback");
    rd(8'h7A, 8'h00, "R2 unmapped 7A");
    rd(8'h00, 8'h00, "R2 unmapped 00");
    wr(8'h70, 8'h00);
    wr(8'h79, 8'hFF); rd(8'h79, 8'h00, "R6 write never sets");

    // rising edge on pin 0, latency check
    wr(8'h78, 8'h0F);
    set_pins(8'h01);
    @(posedge clk);
    rd(8'h79, 8'h00, "R3 not yet at 2nd edge");
    rd(8'h79, 8'h01, "R3 rising sets at 3rd edge");
    chk_irq(1'b1, "R9 irq high");

    wr(8'h79, 8'h01); rd(8'h79, 8'h00, "R6 write one clears");
    chk_irq(1'b0, "R9 irq low");

    set_pins(8'h00); settle();
    rd(8'h79, 8'h01, "R3 falling sets");
    wr(8'h79, 8'h00); rd(8'h79, 8'h01, "R6 write zero keeps");
    wr(8'h79, 8'h01);

    set_pins(8'h10); settle();
    rd(8'h79, 8'h00, "R4 disabled pin ignored");

    wr(8'h70, 8'h02);
    set_pins(8'h12); settle();
    rd(8'h79, 8'h00, "R5 output pin ignored");
    wr(8'h70, 8'h00);

    set_pins(8'h1F); settle();
    rd(8'h79, 8'h0D, "R3 per-pin mapping");

    wr(8'h78, 8'h00);
    rd(8'h79, 8'h0D, "R8 disable keeps status");
    wr(8'h78, 8'h0F);

    // collision: clear write across the edge that sets bit 0
    set_pins(8'h1E);
    @(posedge clk);
    @(posedge clk); #1;
    addr = 8'h79; wdata = 8'h0D; we = 1;
    @(posedge clk); #1;
    we = 0;
    rd(8'h79, 8'h01, "R7 set wins over clear");
    chk_irq(1'b1, "R9 irq after collision");

    repeat (2) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule